// File: doc/BRIEF.md
# Capability tag-tracking memory

This block is a small byte-addressed data memory that also keeps one type bit per aligned granule of `CLEN_BYTES` bytes. The bit says whether the granule currently holds a capability (1) or plain integer data (0). Integer stores of 1, 2, 4 or 8 bytes write only their own bytes, but they retype the whole granule that contains them as integer. A capability store writes a full aligned granule and types it as a capability. Loads come in two flavours. An integer load returns its bytes zero-extended. A capability load returns the whole granule. Both report the granule's type bit.

Stores issued from the normal world pass a permission guard. The guard faults any store that would touch at least one byte of a protected window. The window is bounded by two software-written bound registers, which always hold granule-aligned values. For a store made through a capability whose type field marks it uninitialised, the block also returns the capability cursor advanced by the store size.

Requests and responses each use a valid/ready handshake. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Its response is presented on the next cycle. The block keeps one response slot. `req_ready` falls only while a response is waiting and `rsp_ready` is low. During such a stall the response holds every field steady, so back-pressure on the response side throttles the request side directly, with no extra buffering.

Top module: `cap_tag_mem`

## Requirements
- R1: A request is accepted on a cycle with `req_valid` and `req_ready` high, and its response is valid on the next cycle. `req_ready` is low only while a response is pending and `rsp_ready` is low. A response not taken keeps all of its fields unchanged. Responses come in request order.
- R2: `req_op` encodes integer load as 0, integer store as 1, capability load as 2 and capability store as 3. Bit 0 marks a store and bit 1 marks a capability access. `req_size` 0..3 selects 1, 2, 4 or 8 bytes. An integer store writes `req_wdata` bits [8n-1:0] to bytes addr..addr+n-1 and leaves other bytes alone. An integer load returns those bytes in `rsp_rdata` [8n-1:0], with zeros above.
- R3: An accepted integer store clears the type bit of the granule `addr & ~(CLEN_BYTES-1)`. Every non-faulting load reports its granule's current type bit on `rsp_tag`.
- R4: A capability store writes all `CLEN_BYTES` bytes of `req_wdata` to the aligned granule and sets its type bit. A capability load returns the granule's bytes and its type bit.
- R5: After reset all type bits are 0, both window bounds are 0 (an empty window), `rsp_valid` is 0 and `req_ready` is 1.
- R6: A normal-world store (`req_secure` = 0) of n bytes at address A faults with cause 7 when A + n > base and A < end. A faulted store changes no byte and no type bit. Secure-world stores and all loads skip this window check.
- R7: Writing a bound through `cfg_base_we` or `cfg_end_we` stores `cfg_wdata` with its low log2(`CLEN_BYTES`) bits cleared.
- R8: An access whose address is not a multiple of its size faults before the window check. A capability access counts as `CLEN_BYTES` bytes. A misaligned store reports cause 6 and changes nothing. A misaligned load reports cause 4.
- R9: A non-faulting store with `req_via_cap` = 1 and `req_cap_type` = 3 returns `rsp_cursor` = `req_cursor` + store size. In every other case `rsp_cursor` equals `req_cursor`.
- R10: A response without a fault has `rsp_cause` 0. Faulted responses and all store responses return `rsp_rdata` = 0 and `rsp_tag` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_we | input | 1 | Load the window base from `cfg_wdata` |
| cfg_end_we | input | 1 | Load the window end from `cfg_wdata` |
| cfg_wdata | input | ADDR_W+1 | Bound value, rounded down to a granule |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | Access kind: bit 0 store, bit 1 capability |
| req_size | input | 2 | Integer size as log2 of bytes |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | CLEN_BYTES*8 | Store data, LSB-aligned for integers |
| req_secure | input | 1 | Request issued from the secure world |
| req_via_cap | input | 1 | Store made through a capability |
| req_cap_type | input | 2 | Type field of that capability |
| req_cursor | input | CUR_W | Cursor of that capability |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | CLEN_BYTES*8 | Load data |
| rsp_tag | output | 1 | Granule type bit (1 = capability) |
| rsp_fault | output | 1 | Request faulted |
| rsp_cause | output | 4 | Fault cause code |
| rsp_cursor | output | CUR_W | Cursor after the access |

## Verification
The bench builds the block with its default parameters: 16-byte granules, a 1 KiB memory and a 32-bit cursor. With these values, all four integer sizes fit inside one granule at every aligned offset. The window bounds can therefore be placed so that stores end exactly on the base, start exactly on the end, or straddle either edge. Unaligned bound writes of 0x10F and 0x20F make the rounding visible, because stores at 0x100 and 0x200 are decided differently with and without it. The response consumer drops `rsp_ready` one cycle in four, so stalls hit requests that are issued back to back.

// File: rtl/cap_tag_mem_pkg.sv
package cap_tag_mem_pkg;

  // access kind: bit 0 = store, bit 1 = capability-sized
  typedef enum logic [1:0] {
    OP_LD_INT = 2'd0,
    OP_ST_INT = 2'd1,
    OP_LD_CAP = 2'd2,
    OP_ST_CAP = 2'd3
  } mem_op_e;

  localparam logic [3:0] CAUSE_NONE        = 4'd0;
  localparam logic [3:0] CAUSE_LD_MISALIGN = 4'd4;
  localparam logic [3:0] CAUSE_ST_MISALIGN = 4'd6;
  localparam logic [3:0] CAUSE_ST_ACCESS   = 4'd7;

  localparam logic [1:0] CAP_TYPE_UNINIT = 2'd3;

endpackage

// File: rtl/cap_tag_bounds.sv
module cap_tag_bounds #(
  parameter int BND_W   = 11,
  parameter int GRAN_LG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic             end_we,
  input  logic [BND_W-1:0] wdata,
  output logic [BND_W-1:0] win_base,
  output logic [BND_W-1:0] win_end
);
  localparam logic [BND_W-1:0] LOW_BITS   = BND_W'((1 << GRAN_LG) - 1);
  localparam logic [BND_W-1:0] ALIGN_MASK = ~LOW_BITS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_base <= '0;
      win_end  <= '0;
    end else begin
      if (base_we) win_base <= wdata & ALIGN_MASK;
      if (end_we)  win_end  <= wdata & ALIGN_MASK;
    end
  end
endmodule

// File: rtl/cap_tag_guard.sv
module cap_tag_guard
  import cap_tag_mem_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int BND_W   = 11,
  parameter int GRAN_LG = 4,
  parameter int NB_W    = 5
) (
  input  logic [1:0]        op,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic              secure,
  input  logic [BND_W-1:0]  win_base,
  input  logic [BND_W-1:0]  win_end,
  output logic [NB_W-1:0]   nbytes,
  output logic              fault,
  output logic [3:0]        cause
);
  logic            is_store;
  logic            is_cap;
  logic            misal;
  logic            in_win;
  logic [BND_W:0]  span_end;

  always_comb begin
    is_store = op[0];
    is_cap   = op[1];
    nbytes   = is_cap ? NB_W'(1 << GRAN_LG) : (NB_W'(1) << size);
    misal    = |(addr & ADDR_W'(nbytes - NB_W'(1)));
    span_end = (BND_W+1)'(addr) + (BND_W+1)'(nbytes);
    in_win   = (span_end > {1'b0, win_base}) && (BND_W'(addr) < win_end);

    fault = 1'b0;
    cause = CAUSE_NONE;
    if (misal) begin
      fault = 1'b1;
      cause = is_store ? CAUSE_ST_MISALIGN : CAUSE_LD_MISALIGN;
    end else if (is_store && !secure && in_win) begin
      fault = 1'b1;
      cause = CAUSE_ST_ACCESS;
    end
  end
endmodule

// File: rtl/cap_tag_array.sv
module cap_tag_array #(
  parameter int GRAN_BYTES = 16,
  parameter int IDX_W      = 6,
  localparam int NUM_GRAN  = 1 << IDX_W,
  localparam int GRAN_BITS = GRAN_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [GRAN_BYTES-1:0] wr_be,
  input  logic [GRAN_BITS-1:0]  wr_data,
  input  logic                  wr_tag,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [GRAN_BITS-1:0]  rd_data,
  output logic                  rd_tag
);
  logic [GRAN_BITS-1:0] mem_q [NUM_GRAN];
  logic [NUM_GRAN-1:0]  tag_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < GRAN_BYTES; b++) begin
        if (wr_be[b]) mem_q[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tag_q <= '0;
    else if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_data = mem_q[rd_idx];
  assign rd_tag  = tag_q[rd_idx];
endmodule

// File: rtl/cap_tag_cursor.sv
module cap_tag_cursor #(
  parameter int CUR_W = 32,
  parameter int NB_W  = 5
) (
  input  logic             apply,
  input  logic [CUR_W-1:0] cur_in,
  input  logic [NB_W-1:0]  nbytes,
  output logic [CUR_W-1:0] cur_out
);
  assign cur_out = apply ? (cur_in + CUR_W'(nbytes)) : cur_in;
endmodule

// File: rtl/cap_tag_mem.sv
module cap_tag_mem
  import cap_tag_mem_pkg::*;
#(
  parameter int  CLEN_BYTES = 16,
  parameter int  MEM_BYTES  = 1024,
  parameter int  CUR_W      = 32,
  localparam int GRAN_LG    = $clog2(CLEN_BYTES),
  localparam int ADDR_W     = $clog2(MEM_BYTES),
  localparam int BND_W      = ADDR_W + 1,
  localparam int IDX_W      = ADDR_W - GRAN_LG,
  localparam int GRAN_BITS  = CLEN_BYTES * 8,
  localparam int NB_W       = GRAN_LG + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_base_we,
  input  logic                 cfg_end_we,
  input  logic [BND_W-1:0]     cfg_wdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_op,
  input  logic [1:0]           req_size,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [GRAN_BITS-1:0] req_wdata,
  input  logic                 req_secure,
  input  logic                 req_via_cap,
  input  logic [1:0]           req_cap_type,
  input  logic [CUR_W-1:0]     req_cursor,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [GRAN_BITS-1:0] rsp_rdata,
  output logic                 rsp_tag,
  output logic                 rsp_fault,
  output logic [3:0]           rsp_cause,
  output logic [CUR_W-1:0]     rsp_cursor
);
  localparam int OFF_BITS_W = GRAN_LG + 3;

  logic [BND_W-1:0]      win_base;
  logic [BND_W-1:0]      win_end;
  logic [NB_W-1:0]       nbytes;
  logic                  acc_fault;
  logic [3:0]            acc_cause;
  logic                  accept;
  logic                  is_store;
  logic                  is_cap;
  logic [IDX_W-1:0]      gran_idx;
  logic [GRAN_LG-1:0]    offset;
  logic [OFF_BITS_W-1:0] bit_off;
  logic [CLEN_BYTES-1:0] byte_keep;
  logic [GRAN_BITS-1:0]  keep_bits;
  logic [CLEN_BYTES-1:0] st_be;
  logic [GRAN_BITS-1:0]  st_data;
  logic                  wr_en;
  logic [GRAN_BITS-1:0]  rd_granule;
  logic                  rd_tag;
  logic [GRAN_BITS-1:0]  ld_data;
  logic                  cur_apply;
  logic [CUR_W-1:0]      cur_next;

  assign is_store = req_op[0];
  assign is_cap   = req_op[1];
  assign gran_idx = req_addr[ADDR_W-1:GRAN_LG];
  assign offset   = req_addr[GRAN_LG-1:0];
  assign bit_off  = {offset, 3'b000};

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  cap_tag_bounds #(.BND_W(BND_W), .GRAN_LG(GRAN_LG)) u_bounds (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_we  (cfg_base_we),
    .end_we   (cfg_end_we),
    .wdata    (cfg_wdata),
    .win_base (win_base),
    .win_end  (win_end)
  );

  cap_tag_guard #(.ADDR_W(ADDR_W), .BND_W(BND_W), .GRAN_LG(GRAN_LG), .NB_W(NB_W)) u_guard (
    .op       (req_op),
    .size     (req_size),
    .addr     (req_addr),
    .secure   (req_secure),
    .win_base (win_base),
    .win_end  (win_end),
    .nbytes   (nbytes),
    .fault    (acc_fault),
    .cause    (acc_cause)
  );

  // byte lanes covered by an access of nbytes starting at lane 0
  always_comb begin
    for (int b = 0; b < CLEN_BYTES; b++) begin
      byte_keep[b]         = (b < int'(nbytes));
      keep_bits[b*8 +: 8]  = {8{byte_keep[b]}};
    end
  end

  assign st_be   = is_cap ? '1 : (byte_keep << offset);
  assign st_data = is_cap ? req_wdata : (req_wdata << bit_off);
  assign wr_en   = accept && is_store && !acc_fault;

  cap_tag_array #(.GRAN_BYTES(CLEN_BYTES), .IDX_W(IDX_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (gran_idx),
    .wr_be   (st_be),
    .wr_data (st_data),
    .wr_tag  (is_cap),
    .rd_idx  (gran_idx),
    .rd_data (rd_granule),
    .rd_tag  (rd_tag)
  );

  assign ld_data = is_cap ? rd_granule : ((rd_granule >> bit_off) & keep_bits);

  assign cur_apply = req_via_cap && is_store && (req_cap_type == CAP_TYPE_UNINIT) && !acc_fault;

  cap_tag_cursor #(.CUR_W(CUR_W), .NB_W(NB_W)) u_cursor (
    .apply   (cur_apply),
    .cur_in  (req_cursor),
    .nbytes  (nbytes),
    .cur_out (cur_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_tag    <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_cause  <= CAUSE_NONE;
      rsp_cursor <= '0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_rdata  <= (is_store || acc_fault) ? '0 : ld_data;
      rsp_tag    <= (is_store || acc_fault) ? 1'b0 : rd_tag;
      rsp_fault  <= acc_fault;
      rsp_cause  <= acc_cause;
      rsp_cursor <= cur_next;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/cap_tag_mem_chk.sv
module cap_tag_mem_chk #(
  parameter int ADDR_W    = 10,
  parameter int BND_W     = 11,
  parameter int GRAN_LG   = 4,
  parameter int GRAN_BITS = 128,
  parameter int CUR_W     = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [1:0]           req_op,
  input logic [1:0]           req_size,
  input logic [ADDR_W-1:0]    req_addr,
  input logic                 req_secure,
  input logic [CUR_W-1:0]     req_cursor,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [GRAN_BITS-1:0] rsp_rdata,
  input logic                 rsp_tag,
  input logic                 rsp_fault,
  input logic [3:0]           rsp_cause,
  input logic [CUR_W-1:0]     rsp_cursor,
  input logic [BND_W-1:0]     win_base,
  input logic [BND_W-1:0]     win_end
);
  logic              taken;
  logic [BND_W:0]    n_len;
  logic              n_aligned;
  logic              n_overlap;

  assign taken     = req_valid && req_ready;
  assign n_len     = req_op[1] ? (BND_W+1)'(1 << GRAN_LG) : ((BND_W+1)'(1) << req_size);
  assign n_aligned = ((BND_W+1)'(req_addr) & (n_len - 1'b1)) == '0;
  assign n_overlap = ((BND_W+1)'(req_addr) + n_len > (BND_W+1)'(win_base)) &&
                     ((BND_W+1)'(req_addr) < (BND_W+1)'(win_end));

  // R1
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> rsp_valid);

  // R1
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_tag)
                               && $stable(rsp_fault) && $stable(rsp_cause) && $stable(rsp_cursor));

  // R1
  stall_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> rsp_valid && !rsp_ready);

  // R6
  window_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && req_op[0] && !req_secure && n_aligned && n_overlap |=> rsp_fault && rsp_cause == 4'd7);

  // R8
  misalign_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && !n_aligned |=> rsp_fault && (rsp_cause == 4'd4 || rsp_cause == 4'd6));

  // R10
  clean_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_cause == 4'd0);

  // R9
  load_cursor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && !req_op[0] |=> rsp_cursor == $past(req_cursor));

  // R7
  bound_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_base[GRAN_LG-1:0] == '0 && win_end[GRAN_LG-1:0] == '0);
endmodule

bind cap_tag_mem cap_tag_mem_chk #(
  .ADDR_W(ADDR_W), .BND_W(BND_W), .GRAN_LG(GRAN_LG), .GRAN_BITS(GRAN_BITS), .CUR_W(CUR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_size(req_size), .req_addr(req_addr), .req_secure(req_secure),
  .req_cursor(req_cursor), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .rsp_tag(rsp_tag), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
  .rsp_cursor(rsp_cursor), .win_base(win_base), .win_end(win_end)
);

// File: tb/cap_tag_mem_test.sv
module cap_tag_mem_test;
  localparam int AW = 10;
  localparam int BW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_base_we = 1'b0, cfg_end_we = 1'b0;
  logic [BW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0, req_size = '0, req_cap_type = '0;
  logic [AW-1:0] req_addr = '0;
  logic [127:0]  req_wdata = '0;
  logic          req_secure = 1'b0, req_via_cap = 1'b0;
  logic [31:0]   req_cursor = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [127:0]  rsp_rdata;
  logic          rsp_tag, rsp_fault;
  logic [3:0]    rsp_cause;
  logic [31:0]   rsp_cursor;

  cap_tag_mem uut (
    .clk(clk), .rst_n(rst_n), .cfg_base_we(cfg_base_we), .cfg_end_we(cfg_end_we),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata), .req_secure(req_secure),
    .req_via_cap(req_via_cap), .req_cap_type(req_cap_type), .req_cursor(req_cursor),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_tag(rsp_tag),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_cursor(rsp_cursor)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, n_sent = 0, n_got = 0, cyc = 0;
  bit done = 0;

  typedef struct packed {
    logic [127:0] data;
    logic         tag;
    logic         fault;
    logic [3:0]   cause;
    logic [31:0]  cur;
    logic         chk_data;
  } exp_t;

  exp_t  exp_q[$];
  string exp_req_q[$];

  logic [7:0] mem_m [1024];
  bit         known_m [1024];
  bit         tag_m [64];
  int         base_m = 0, end_m = 0;

  task automatic check(input bit ok, input string rq, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s", rq, what);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] sz, input int addr,
                       input logic [127:0] wd, input bit sec, input bit via,
                       input logic [1:0] ct, input logic [31:0] cur, input string rq);
    exp_t e;
    int   nb  = op[1] ? 16 : (1 << sz);
    bit   st  = op[0];
    bit   mis = (addr % nb) != 0;
    bit   win = (addr + nb > base_m) && (addr < end_m);
    e = '0;
    e.chk_data = 1'b1;
    if (mis) begin
      e.fault = 1'b1;
      e.cause = st ? 4'd6 : 4'd4;
    end else if (st && !sec && win) begin
      e.fault = 1'b1;
      e.cause = 4'd7;
    end
    if (!e.fault && !st) begin
      e.tag = tag_m[addr / 16];
      for (int i = 0; i < nb; i++) begin
        e.data[i*8 +: 8] = mem_m[addr + i];
        if (!known_m[addr + i]) e.chk_data = 1'b0;
      end
      // integer load after a newer capability store: data left unchecked
      if (!op[1] && tag_m[addr / 16]) e.chk_data = 1'b0;
    end
    if (!e.fault && st) begin
      for (int i = 0; i < nb; i++) begin
        mem_m[addr + i]   = wd[i*8 +: 8];
        known_m[addr + i] = 1'b1;
      end
      tag_m[addr / 16] = op[1];
    end
    e.cur = (via && st && ct == 2'd3 && !e.fault) ? cur + 32'(nb) : cur;

    req_valid = 1'b1; req_op = op; req_size = sz; req_addr = AW'(addr); req_wdata = wd;
    req_secure = sec; req_via_cap = via; req_cap_type = ct; req_cursor = cur;
    while (!req_ready) @(negedge clk);
    exp_q.push_back(e);
    exp_req_q.push_back(rq);
    n_sent++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_bound(input bit is_end, input int v);
    cfg_wdata = BW'(v);
    if (is_end) cfg_end_we = 1'b1; else cfg_base_we = 1'b1;
    @(negedge clk);
    cfg_end_we = 1'b0; cfg_base_we = 1'b0;
    if (is_end) end_m = v & ~15; else base_m = v & ~15;
  endtask

  // response consumer: stalls one cycle in four
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      rsp_ready = (cyc % 4) != 3;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid && !rsp_ready) // R1 stall reaches the request side
        check(req_ready == 1'b0, "R1", $sformatf("req_ready=%0d expected 0 during stall", req_ready));
      if (rsp_valid && rsp_ready) begin
        exp_t  e;
        string rq;
        bit    ok;
        n_got++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "response with no pending request (act=1 exp=0)");
        end else begin
          e  = exp_q.pop_front();
          rq = exp_req_q.pop_front();
          ok = (rsp_tag == e.tag) && (rsp_fault == e.fault) && (rsp_cause == e.cause) &&
               (rsp_cursor == e.cur) && (!e.chk_data || rsp_rdata == e.data);
          check(ok, rq, $sformatf("act data=%h tag=%0d fault=%0d cause=%0d cur=%h | exp data=%h tag=%0d fault=%0d cause=%0d cur=%h",
                rsp_rdata, rsp_tag, rsp_fault, rsp_cause, rsp_cursor,
                e.data, e.tag, e.fault, e.cause, e.cur));
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired: got=%0d expected=%0d responses", n_got, n_sent);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin mem_m[i] = '0; known_m[i] = 1'b0; end
    for (int i = 0; i < 64; i++) tag_m[i] = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    check(rsp_valid == 1'b0, "R5", $sformatf("rsp_valid=%0d expected 0", rsp_valid));
    check(req_ready == 1'b1, "R5", $sformatf("req_ready=%0d expected 1", req_ready));
    issue(2'd2, 2'd0, 'h50, '0, 0, 0, 2'd0, 32'h0, "R5");      // tag 0 after reset
    issue(2'd1, 2'd0, 'h300, 128'h5A, 0, 0, 2'd0, 32'h0, "R5"); // empty window: no fault

    // R2 integer stores and loads of every size
    issue(2'd1, 2'd0, 'h40, 128'hA1, 0, 0, 2'd0, 0, "R2");
    issue(2'd1, 2'd0, 'h41, 128'hB2, 0, 0, 2'd0, 0, "R2");
    issue(2'd1, 2'd1, 'h42, 128'hC3D4, 0, 0, 2'd0, 0, "R2");
    issue(2'd1, 2'd2, 'h44, 128'h11223344, 0, 0, 2'd0, 0, "R2");
    issue(2'd1, 2'd3, 'h48, 128'hFFEE_DDCC_BBAA_9988_0102030405060708, 0, 0, 2'd0, 0, "R2");
    issue(2'd0, 2'd3, 'h40, '0, 0, 0, 2'd0, 0, "R2");
    issue(2'd0, 2'd0, 'h41, '0, 0, 0, 2'd0, 0, "R2");
    issue(2'd0, 2'd1, 'h42, '0, 0, 0, 2'd0, 0, "R2");
    issue(2'd0, 2'd2, 'h44, '0, 0, 0, 2'd0, 0, "R2");
    issue(2'd0, 2'd3, 'h48, '0, 0, 0, 2'd0, 0, "R2");

    // R4 capability store and load; R3 integer load reports the tag
    issue(2'd3, 2'd0, 'h80, 128'h0F0E0D0C_0B0A0908_07060504_03020100, 0, 0, 2'd0, 0, "R4");
    issue(2'd2, 2'd0, 'h80, '0, 0, 0, 2'd0, 0, "R4");
    issue(2'd0, 2'd3, 'h88, '0, 0, 0, 2'd0, 0, "R3");
    issue(2'd1, 2'd0, 'h83, 128'h77, 0, 0, 2'd0, 0, "R3");      // byte store retypes granule
    issue(2'd2, 2'd0, 'h80, '0, 0, 0, 2'd0, 0, "R3");
    issue(2'd3, 2'd0, 'h90, {4{32'hCAFE_F00D}}, 0, 0, 2'd0, 0, "R4");
    issue(2'd2, 2'd0, 'h90, '0, 0, 0, 2'd0, 0, "R4");

    // R8 misalignment, R10 clean data on faults
    issue(2'd1, 2'd2, 'h42, 128'hDEAD, 0, 0, 2'd0, 0, "R8");
    issue(2'd0, 2'd3, 'h40, '0, 0, 0, 2'd0, 0, "R8");
    issue(2'd3, 2'd0, 'h88, '1, 0, 0, 2'd0, 0, "R8");
    issue(2'd2, 2'd0, 'h80, '0, 0, 0, 2'd0, 0, "R8");
    issue(2'd0, 2'd1, 'h41, '0, 0, 0, 2'd0, 0, "R10");
    issue(2'd2, 2'd0, 'h84, '0, 0, 0, 2'd0, 0, "R10");

    // R7 rounded bounds, R6 window guard
    set_bound(0, 'h10F);
    set_bound(1, 'h20F);
    issue(2'd1, 2'd3, 'hF8, 128'h1, 0, 0, 2'd0, 0, "R6");      // ends on base: allowed
    issue(2'd1, 2'd3, 'h100, 128'h2, 0, 0, 2'd0, 0, "R7");     // faults only if base rounded
    issue(2'd1, 2'd3, 'h200, 128'h3, 0, 0, 2'd0, 0, "R7");     // allowed only if end rounded
    issue(2'd3, 2'd0, 'hF0, 128'h4, 0, 0, 2'd0, 0, "R6");
    issue(2'd1, 2'd3, 'h1F8, 128'h1234, 1, 0, 2'd0, 0, "R6");  // secure world exempt
    issue(2'd1, 2'd3, 'h1F8, 128'h9999, 0, 0, 2'd0, 0, "R6");
    issue(2'd0, 2'd3, 'h1F8, '0, 0, 0, 2'd0, 0, "R6");         // load skips guard
    issue(2'd3, 2'd0, 'h100, '1, 0, 0, 2'd0, 0, "R6");
    issue(2'd2, 2'd0, 'h100, '0, 0, 0, 2'd0, 0, "R6");

    // R9 cursor update
    issue(2'd1, 2'd2, 'h60, 128'h1, 0, 1, 2'd3, 32'h1000, "R9");
    issue(2'd1, 2'd2, 'h64, 128'h2, 0, 1, 2'd2, 32'h1000, "R9");
    issue(2'd3, 2'd0, 'hA0, 128'h3, 0, 1, 2'd3, 32'h2000, "R9");
    issue(2'd1, 2'd3, 'h108, 128'h4, 0, 1, 2'd3, 32'h3000, "R9");
    issue(2'd0, 2'd2, 'h60, '0, 0, 1, 2'd3, 32'h4000, "R9");
    issue(2'd1, 2'd0, 'h61, 128'h5, 0, 0, 2'd3, 32'h5000, "R9");

    for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    // R1 every accepted request answered once
    check(n_got == n_sent && exp_q.size() == 0, "R1",
          $sformatf("responses=%0d expected %0d", n_got, n_sent));
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule